// File: doc/BRIEF.md
# TMDS Character Decoder and Colour/Sync Demultiplexer

This block sits behind the serial front end of a digital video receiver. Each pixel clock it takes one 10-bit transition-minimised character from each of three lanes. The lanes arrive already aligned to character boundaries and to each other. A character is either a data character carrying one 8-bit colour component or one of four control characters carrying a 2-bit control pair. The block turns them into a 24-bit pixel, a data-enable flag, horizontal and vertical sync and three general-purpose control lines, all registered.

Lane 0 is the lead lane. Its character class decides whether the link is in active video or in blanking, and a small link state machine tracks this. In active video the three decoded components form the pixel, and every control output is frozen. In blanking each lane's control pair updates its own control lines, and the pixel output is frozen. The state machine has three states. `LINK_IDLE` is the state held during reset and left on the first clock after it. `LINK_BLANK` is entered by the transition *to_blank* whenever the lead-lane character is a control code. `LINK_ACTIVE` is entered by the transition *to_active* whenever the lead-lane character is anything else. Both transitions are taken from every state, so the state always follows the previous cycle's lead-lane class.

Top module: `tmds_rx_demux`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it has been sampled high, `pixel_o`, `de_o`, `hsync_o`, `vsync_o`, `ctl1_o`, `ctl2_o` and `ctl3_o` are all 0.
- R2: The control characters 10'b1101010100, 10'b0010101011, 10'b0101010100 and 10'b1010101011 carry the pairs 00, 01, 10 and 11. On lane 0 the low pair bit becomes `hsync_o` and the high pair bit becomes `vsync_o`.
- R3: A control character on lane 1 drives `ctl1_o` with its low pair bit. Its high pair bit changes no output.
- R4: A control character on lane 2 drives `ctl2_o` with its low pair bit and `ctl3_o` with its high pair bit.
- R5: A data character decodes as follows. If bit 9 is set, bits 7:0 are first inverted, giving d. Output bit 0 equals d[0]. Output bit k (k = 1..7) equals d[k] XOR d[k-1] when bit 8 is 1, and the XNOR of those bits when bit 8 is 0.
- R6: The pixel is packed with the lane 2 (red) component in bits 23:16, the lane 1 (green) component in bits 15:8 and the lane 0 (blue) component in bits 7:0.
- R7: `de_o` is 1 exactly when the lane 0 character of the previous clock was not one of the four control characters. Every output appears one clock after its characters are sampled.
- R8: While `de_o` is 1, none of `hsync_o`, `vsync_o`, `ctl1_o`, `ctl2_o` and `ctl3_o` changes.
- R9: While `de_o` is 0, `pixel_o` keeps the value it last took in active video, or 0 if there has been no active video since reset.
- R10: During blanking, a character on lane 1 or lane 2 that is not a control character leaves that lane's control lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lane0_char_i | input | 10 | Aligned character of the lead lane (blue, sync pair) |
| lane1_char_i | input | 10 | Aligned character of lane 1 (green, control line 1) |
| lane2_char_i | input | 10 | Aligned character of lane 2 (red, control lines 2 and 3) |
| pixel_o | output | 24 | Decoded pixel, red high, blue low |
| de_o | output | 1 | Data enable: 1 in active video, 0 in blanking |
| hsync_o | output | 1 | Horizontal sync from lane 0 low pair bit |
| vsync_o | output | 1 | Vertical sync from lane 0 high pair bit |
| ctl1_o | output | 1 | Control line 1 from lane 1 low pair bit |
| ctl2_o | output | 1 | Control line 2 from lane 2 low pair bit |
| ctl3_o | output | 1 | Control line 3 from lane 2 high pair bit |

## Verification
The link state machine shows at the ports through `de_o`. A wrong transition therefore appears as a wrong data-enable one clock after the offending lead-lane character. It also causes a pixel update where one should have been held, or the reverse, in the same cycle. A wrong control register shows as a sync or control line that differs from the last pair sent on its lane. The reference model checks every output on every clock, so such faults are caught in the first cycle they are visible. That cycle is either the next blanking character on that lane or the first held cycle that follows. Encoded bytes use random inversion and both chaining modes, so a decoder fault reaches the pixel output one clock after the character that exposes it.

// File: rtl/tmds_rx_pkg.sv
package tmds_rx_pkg;

    // Width of one colour component and of the line character carrying it.
    localparam int COMP_W    = 8;
    localparam int CHAR_W    = COMP_W + 2;
    localparam int NUM_LANES = 3;
    localparam int PIX_W     = NUM_LANES * COMP_W;

    // Bit positions inside a data character.
    localparam int INV_BIT   = COMP_W + 1;   // body was inverted by the sender
    localparam int XOR_BIT   = COMP_W;       // 1: XOR chaining, 0: XNOR chaining

    // The four control characters, indexed by the pair they carry.
    localparam logic [CHAR_W-1:0] CTRL_PAIR_00 = 10'b1101010100;
    localparam logic [CHAR_W-1:0] CTRL_PAIR_01 = 10'b0010101011;
    localparam logic [CHAR_W-1:0] CTRL_PAIR_10 = 10'b0101010100;
    localparam logic [CHAR_W-1:0] CTRL_PAIR_11 = 10'b1010101011;

    // Link state: follows the class of the previous lead-lane character.
    typedef enum logic [1:0] {
        LINK_IDLE   = 2'd0,
        LINK_BLANK  = 2'd1,
        LINK_ACTIVE = 2'd2
    } link_state_e;

    // Number of control lines each lane feeds: lane 1 feeds a single line.
    function automatic int lane_ctrl_bits(input int lane);
        return (lane == 1) ? 1 : 2;
    endfunction

    // Position of a lane's first control line in the flat control vector.
    function automatic int lane_ctrl_offset(input int lane);
        int acc;
        acc = 0;
        for (int i = 0; i < lane; i++) begin
            acc += lane_ctrl_bits(i);
        end
        return acc;
    endfunction

    localparam int CTRL_TOTAL = lane_ctrl_offset(NUM_LANES);

    // Flat control vector layout.
    localparam int CTRL_HSYNC = 0;
    localparam int CTRL_VSYNC = 1;
    localparam int CTRL_CTL1  = 2;
    localparam int CTRL_CTL2  = 3;
    localparam int CTRL_CTL3  = 4;

endpackage

// File: rtl/tmds_lane_decode.sv
module tmds_lane_decode
    import tmds_rx_pkg::*;
#(
    parameter int CTRL_BITS = 2
) (
    input  logic [CHAR_W-1:0]    char_i,
    output logic                 is_ctrl_o,
    output logic [CTRL_BITS-1:0] ctrl_o,
    output logic [COMP_W-1:0]    comp_o
);

    logic [1:0]        pair_w;
    logic [COMP_W-1:0] body_w;
    logic [COMP_W-1:0] comp_w;

    // Control character classification.
    always_comb begin
        is_ctrl_o = 1'b1;
        pair_w    = 2'b00;
        unique case (char_i)
            CTRL_PAIR_00: pair_w = 2'b00;
            CTRL_PAIR_01: pair_w = 2'b01;
            CTRL_PAIR_10: pair_w = 2'b10;
            CTRL_PAIR_11: pair_w = 2'b11;
            default: begin
                is_ctrl_o = 1'b0;
                pair_w    = 2'b00;
            end
        endcase
    end

    // Lanes feeding fewer lines keep the low pair bits.
    assign ctrl_o = CTRL_BITS'(pair_w);

    // Data character: undo the optional inversion, then undo the chaining.
    always_comb begin
        body_w    = char_i[INV_BIT] ? ~char_i[COMP_W-1:0] : char_i[COMP_W-1:0];
        comp_w    = '0;
        comp_w[0] = body_w[0];
        for (int k = 1; k < COMP_W; k++) begin
            if (char_i[XOR_BIT]) begin
                comp_w[k] = body_w[k] ^ body_w[k-1];
            end else begin
                comp_w[k] = ~(body_w[k] ^ body_w[k-1]);
            end
        end
    end

    assign comp_o = comp_w;

endmodule

// File: rtl/tmds_link_fsm.sv
module tmds_link_fsm
    import tmds_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lead_is_ctrl_i,
    output link_state_e state_o,
    output logic        load_pix_o,
    output logic        load_ctrl_o
);

    link_state_e state_q;
    link_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LINK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: to_blank on a lead control character, to_active otherwise.
    always_comb begin
        state_d = LINK_IDLE;
        unique case (state_q)
            LINK_IDLE:   state_d = lead_is_ctrl_i ? LINK_BLANK : LINK_ACTIVE;
            LINK_BLANK:  state_d = lead_is_ctrl_i ? LINK_BLANK : LINK_ACTIVE;
            LINK_ACTIVE: state_d = lead_is_ctrl_i ? LINK_BLANK : LINK_ACTIVE;
            default:     state_d = LINK_IDLE;
        endcase
    end

    // Outputs: which register bank the coming edge loads.
    always_comb begin
        load_pix_o  = 1'b0;
        load_ctrl_o = 1'b0;
        if (!rst) begin
            unique case (state_d)
                LINK_ACTIVE: load_pix_o  = 1'b1;
                LINK_BLANK:  load_ctrl_o = 1'b1;
                default: begin
                    load_pix_o  = 1'b0;
                    load_ctrl_o = 1'b0;
                end
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/tmds_out_regs.sv
module tmds_out_regs
    import tmds_rx_pkg::*;
#(
    parameter int P_W = PIX_W,
    parameter int C_W = CTRL_TOTAL
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_pix_i,
    input  logic [P_W-1:0] pix_d_i,
    input  logic [C_W-1:0] ctrl_en_i,
    input  logic [C_W-1:0] ctrl_d_i,
    output logic [P_W-1:0] pix_q_o,
    output logic [C_W-1:0] ctrl_q_o
);

    logic [P_W-1:0] pix_q;
    logic [C_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q <= '0;
        end else if (load_pix_i) begin
            pix_q <= pix_d_i;
        end
    end

    // Each control line has its own enable, so lanes update independently.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= (ctrl_q & ~ctrl_en_i) | (ctrl_d_i & ctrl_en_i);
        end
    end

    assign pix_q_o  = pix_q;
    assign ctrl_q_o = ctrl_q;

endmodule

// File: rtl/tmds_rx_demux.sv
module tmds_rx_demux
    import tmds_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAR_W-1:0] lane0_char_i,
    input  logic [CHAR_W-1:0] lane1_char_i,
    input  logic [CHAR_W-1:0] lane2_char_i,
    output logic [PIX_W-1:0]  pixel_o,
    output logic              de_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              ctl1_o,
    output logic              ctl2_o,
    output logic              ctl3_o
);

    logic [CHAR_W-1:0]     lane_char [NUM_LANES];
    logic [NUM_LANES-1:0]  lane_is_ctrl;
    logic [PIX_W-1:0]      pix_d;
    logic [CTRL_TOTAL-1:0] ctrl_d;
    logic [CTRL_TOTAL-1:0] ctrl_en;
    logic [CTRL_TOTAL-1:0] ctrl_q;
    logic                  load_pix;
    logic                  load_ctrl;
    link_state_e           link_state;

    assign lane_char[0] = lane0_char_i;
    assign lane_char[1] = lane1_char_i;
    assign lane_char[2] = lane2_char_i;

    // One decoder per lane; lane index picks its control width and slot.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int NB  = lane_ctrl_bits(g);
        localparam int OFF = lane_ctrl_offset(g);

        logic [NB-1:0] ctrl_w;

        tmds_lane_decode #(
            .CTRL_BITS (NB)
        ) i_dec (
            .char_i    (lane_char[g]),
            .is_ctrl_o (lane_is_ctrl[g]),
            .ctrl_o    (ctrl_w),
            .comp_o    (pix_d[g*COMP_W +: COMP_W])
        );

        assign ctrl_d[OFF +: NB]  = ctrl_w;
        assign ctrl_en[OFF +: NB] = {NB{load_ctrl & lane_is_ctrl[g]}};
    end

    tmds_link_fsm i_fsm (
        .clk            (clk),
        .rst            (rst),
        .lead_is_ctrl_i (lane_is_ctrl[0]),
        .state_o        (link_state),
        .load_pix_o     (load_pix),
        .load_ctrl_o    (load_ctrl)
    );

    tmds_out_regs #(
        .P_W (PIX_W),
        .C_W (CTRL_TOTAL)
    ) i_regs (
        .clk        (clk),
        .rst        (rst),
        .load_pix_i (load_pix),
        .pix_d_i    (pix_d),
        .ctrl_en_i  (ctrl_en),
        .ctrl_d_i   (ctrl_d),
        .pix_q_o    (pixel_o),
        .ctrl_q_o   (ctrl_q)
    );

    assign de_o    = (link_state == LINK_ACTIVE);
    assign hsync_o = ctrl_q[CTRL_HSYNC];
    assign vsync_o = ctrl_q[CTRL_VSYNC];
    assign ctl1_o  = ctrl_q[CTRL_CTL1];
    assign ctl2_o  = ctrl_q[CTRL_CTL2];
    assign ctl3_o  = ctrl_q[CTRL_CTL3];

endmodule

// File: rtl/tmds_rx_demux_chk.sv
module tmds_rx_demux_chk
    import tmds_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CHAR_W-1:0] lane0_char_i,
    input logic [CHAR_W-1:0] lane1_char_i,
    input logic [CHAR_W-1:0] lane2_char_i,
    input logic [PIX_W-1:0]  pixel_o,
    input logic              de_o,
    input logic              hsync_o,
    input logic              vsync_o,
    input logic              ctl1_o,
    input logic              ctl2_o,
    input logic              ctl3_o
);

    logic lead_ctrl;
    assign lead_ctrl = (lane0_char_i == CTRL_PAIR_00) || (lane0_char_i == CTRL_PAIR_01) ||
                       (lane0_char_i == CTRL_PAIR_10) || (lane0_char_i == CTRL_PAIR_11);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!de_o && pixel_o == '0 && !hsync_o && !vsync_o && !ctl1_o && !ctl2_o && !ctl3_o));

    assert_sync_pair11_R2: assert property (@(posedge clk) disable iff (rst)
        (lane0_char_i == CTRL_PAIR_11) |=> (hsync_o && vsync_o));

    assert_sync_pair00_R2: assert property (@(posedge clk) disable iff (rst)
        (lane0_char_i == CTRL_PAIR_00) |=> (!hsync_o && !vsync_o));

    assert_ctl1_set_R3: assert property (@(posedge clk) disable iff (rst)
        (lead_ctrl && lane1_char_i == CTRL_PAIR_01) |=> ctl1_o);

    assert_ctl23_R4: assert property (@(posedge clk) disable iff (rst)
        (lead_ctrl && lane2_char_i == CTRL_PAIR_10) |=> (ctl3_o && !ctl2_o));

    assert_de_blank_R7: assert property (@(posedge clk) disable iff (rst)
        lead_ctrl |=> !de_o);

    assert_de_active_R7: assert property (@(posedge clk) disable iff (rst)
        !lead_ctrl |=> de_o);

    assert_ctrl_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        de_o |-> $stable({ctl3_o, ctl2_o, ctl1_o, vsync_o, hsync_o}));

    assert_pixel_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        !de_o |-> $stable(pixel_o));

endmodule

bind tmds_rx_demux tmds_rx_demux_chk i_chk (.*);

// File: tb/test_tmds_rx_demux.sv
module test_tmds_rx_demux;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  ch0 = 10'b1101010100;
    logic [9:0]  ch1 = 10'b1101010100;
    logic [9:0]  ch2 = 10'b1101010100;
    logic [23:0] pixel;
    logic        de, hs, vs, c1, c2, c3;

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";

    // Reference model state.
    logic        m_de  = 1'b0;
    logic [23:0] m_pix = '0;
    logic        m_hs  = 1'b0, m_vs = 1'b0, m_c1 = 1'b0, m_c2 = 1'b0, m_c3 = 1'b0;

    always #4 clk = ~clk;

    tmds_rx_demux i_tmds_rx_demux (
        .clk          (clk),
        .rst          (rst),
        .lane0_char_i (ch0),
        .lane1_char_i (ch1),
        .lane2_char_i (ch2),
        .pixel_o      (pixel),
        .de_o         (de),
        .hsync_o      (hs),
        .vsync_o      (vs),
        .ctl1_o       (c1),
        .ctl2_o       (c2),
        .ctl3_o       (c3)
    );

    function automatic logic [9:0] ctrl_code(input logic [1:0] p);
        case (p)
            2'b00:   return 10'b1101010100;
            2'b01:   return 10'b0010101011;
            2'b10:   return 10'b0101010100;
            default: return 10'b1010101011;
        endcase
    endfunction

    // Sender-side encoding: transition minimisation, then optional inversion.
    function automatic logic [9:0] encode(input logic [7:0] b, input logic inv);
        int         n1;
        logic       use_xnor;
        logic [7:0] q;
        n1       = $countones(b);
        use_xnor = (n1 > 4) || (n1 == 4 && !b[0]);
        q[0]     = b[0];
        for (int i = 1; i < 8; i++) begin
            q[i] = use_xnor ? ~(q[i-1] ^ b[i]) : (q[i-1] ^ b[i]);
        end
        return {inv, ~use_xnor, inv ? ~q : q};
    endfunction

    function automatic logic [9:0] junk_code();
        logic [9:0] j;
        j = 10'($urandom);
        if (j == 10'b1101010100 || j == 10'b0010101011 ||
            j == 10'b0101010100 || j == 10'b1010101011) begin
            j[4] = ~j[4];
        end
        return j;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h t=%0t", req, phase, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R7 de", 32'(de), 32'(m_de));
        chk(m_de ? "R8 hsync/vsync" : "R2 hsync/vsync", 32'({vs, hs}), 32'({m_vs, m_hs}));
        chk(m_de ? "R8 ctl1" : "R3 ctl1", 32'(c1), 32'(m_c1));
        chk(m_de ? "R8 ctl3/ctl2" : "R4 ctl3/ctl2", 32'({c3, c2}), 32'({m_c3, m_c2}));
        chk(m_de ? "R5 R6 pixel" : "R9 pixel", 32'(pixel), 32'(m_pix));
    endtask

    // Active-video cycle: drive three encoded components, then check.
    task automatic send_pixel(input logic [23:0] px);
        ch0   = encode(px[7:0],   1'($urandom));
        ch1   = encode(px[15:8],  1'($urandom));
        ch2   = encode(px[23:16], 1'($urandom));
        m_de  = 1'b1;
        m_pix = px;
        @(negedge clk);
        compare_all();
    endtask

    // Blanking cycle; a lane flagged as junk carries a non-control character.
    task automatic send_blank(input logic [1:0] p0, input logic [1:0] p1, input logic [1:0] p2,
                              input logic junk1, input logic junk2);
        ch0  = ctrl_code(p0);
        ch1  = junk1 ? junk_code() : ctrl_code(p1);
        ch2  = junk2 ? junk_code() : ctrl_code(p2);
        m_de = 1'b0;
        m_hs = p0[0];
        m_vs = p0[1];
        if (!junk1) m_c1 = p1[0];
        if (!junk2) begin
            m_c2 = p2[0];
            m_c3 = p2[1];
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        logic [7:0] corners [8];
        corners = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80, 8'h0F, 8'hF0};

        // R1: outputs cleared during reset.
        repeat (3) @(negedge clk);
        compare_all();
        rst = 1'b0;
        // R9: blanking straight after reset keeps the pixel at zero.
        send_blank(2'b00, 2'b00, 2'b00, 1'b0, 1'b0);
        compare_all();

        // R2 R3 R4: every pair on every lane.
        phase = "R2 R3 R4";
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                send_blank(2'(a), 2'(b), 2'(3 - b), 1'b0, 1'b0);
            end
        end

        // R5 R6 R7: corner bytes in each lane position, both inversions.
        phase = "R5 R6 R7";
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                send_pixel({corners[i], corners[j], corners[(i + j) % 8]});
            end
        end
        for (int n = 0; n < 300; n++) begin
            send_pixel(24'($urandom));
        end

        // R8 R9 R7: random mix of active and blanking runs.
        phase = "R7 R8 R9";
        for (int n = 0; n < 2000; n++) begin
            if (($urandom % 10) < 6) begin
                send_pixel(24'($urandom));
            end else begin
                send_blank(2'($urandom), 2'($urandom), 2'($urandom), 1'b0, 1'b0);
            end
        end

        // R10: non-control characters on lanes 1 and 2 during blanking.
        phase = "R10";
        for (int n = 0; n < 300; n++) begin
            send_blank(2'($urandom), 2'($urandom), 2'($urandom),
                       1'($urandom), 1'($urandom));
            if (n % 7 == 0) send_pixel(24'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog [%s] actual=running expected=finished", phase);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule